// File: doc/BRIEF.md
# ALU Status Flag Generator

A 16-bit arithmetic and logic unit that computes a result from two operands in a single combinational pass and derives five status flags from it. It adds and subtracts with or without an incoming carry, applies bitwise AND, OR and XOR, and shifts by one place left, logically right or arithmetically right. Every operation runs on either the full word or only the low byte, as the byte select input chooses. The carry and digit-carry flags act as inverted borrow on subtraction.

A five-bit flags register holds the status between operations. When the enable input is high, the register loads the next flag values at the clock edge. Each operation changes only the flags it is defined to affect. The zero flag has a second behaviour for the carry-chained operations: it can be cleared but never set. Because of this, a multi-word add or subtract, built from one plain step and then carried steps, reports zero only if every word of the total result was zero.

Top module: `alu_flag_unit`

## Requirements
- R1: An add (op 0) gives a + b and an add-with-carry (op 1) gives a + b + cin, both modulo the active width. The carry flag (flag bit 0) takes the carry out of the top bit of the active width.
- R2: A subtract (op 2) gives a - b and a subtract-with-borrow (op 3) gives a - b - (1 - cin). The carry flag is 1 when no borrow occurs and 0 when a borrow occurs.
- R3: On add and subtract ops, the digit-carry flag (flag bit 4) takes the carry out of bit 3 in byte mode and out of bit 7 in word mode. On subtraction it is likewise an inverted borrow.
- R4: For every op except the reserved codes, the negative flag (flag bit 3) equals the top bit of the active-width result.
- R5: On add and subtract ops, the overflow flag (flag bit 2) is 1 exactly when two's-complement overflow occurs.
- R6: On ops 0, 2 and 4 to 9, the zero flag (flag bit 1) is 1 exactly when the active-width result is zero.
- R7: On ops 1 and 3, the zero flag is 1 only if the result is zero and the registered zero flag is already 1.
- R8: The logic ops AND (op 4), OR (op 5) and XOR (op 6) update only the zero and negative flags. Carry, overflow and digit-carry keep their registered values.
- R9: Shift left (op 7), logical shift right (op 8) and arithmetic shift right (op 9) move the operand a by one place. The carry flag takes the bit shifted out. Overflow and digit-carry are kept.
- R10: With byte_mode = 1, the upper 8 result bits are zero. Every flag is taken from the low 8 bits only.
- R11: Reset clears the flags register. With en = 1 the register loads flags_next at the clock edge. With en = 0 it holds its value.
- R12: The reserved op codes 10 to 15 give a result of zero and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flags register |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Load flags_next into the flags register |
| op | input | 4 | Operation code |
| byte_mode | input | 1 | 1 selects an 8-bit operation |
| a | input | 16 | First operand, also the shift source |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry / inverted borrow into chained ops |
| result | output | 16 | Operation result |
| flags_next | output | 5 | Next flags {DC, N, OV, Z, C} |
| flags | output | 5 | Registered flags, same bit order |

## Verification
The hardest case to reach is the held zero flag. A chain must first set the registered zero flag with a zero-result plain op. Carried ops then have to follow, some with zero results and some without, and the bench must show that a later zero result cannot bring the flag back. The stimulus runs this exact sequence in both widths, and also puts a logic op and a reserved op after a carry has been set, to show that the kept flags survive. Random operands with the flags register enabled then cover carries at bit 3, bit 7 and bit 15.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   op,
  input  logic         byte_mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] result,
  output logic [4:0]   flags_next,
  output logic [4:0]   flags
);
  localparam int H  = W / 2;
  localparam int Q  = W / 4;
  localparam int FC = 0, FZ = 1, FV = 2, FN = 3, FD = 4;

  localparam logic [3:0] OP_ADD = 4'd0, OP_ADDC = 4'd1, OP_SUB = 4'd2, OP_SUBB = 4'd3,
                         OP_AND = 4'd4, OP_OR = 4'd5, OP_XOR = 4'd6,
                         OP_SL = 4'd7, OP_LSR = 4'd8, OP_ASR = 4'd9;

  logic is_sub, is_ext, is_arith, is_logic, is_shift;
  assign is_sub   = (op == OP_SUB) || (op == OP_SUBB);
  assign is_ext   = (op == OP_ADDC) || (op == OP_SUBB);
  assign is_arith = (op <= OP_SUBB);
  assign is_logic = (op >= OP_AND) && (op <= OP_XOR);
  assign is_shift = (op >= OP_SL) && (op <= OP_ASR);

  logic [W-1:0] bx;
  logic         ci;
  assign bx = is_sub ? ~b : b;
  assign ci = (op == OP_ADD) ? 1'b0 : (op == OP_SUB) ? 1'b1 : cin;

  logic [Q:0] s_q;
  logic [H:0] s_h;
  logic [W:0] s_w;
  assign s_q = {1'b0, a[Q-1:0]} + {1'b0, bx[Q-1:0]} + {{Q{1'b0}}, ci};
  assign s_h = {1'b0, a[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, ci};
  assign s_w = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};

  logic [W-1:0] mask;
  assign mask = byte_mode ? {{H{1'b0}}, {H{1'b1}}} : {W{1'b1}};

  logic [W-1:0] r_sum, r_sl, r_lsr, r_asr;
  assign r_sum = byte_mode ? {{H{1'b0}}, s_h[H-1:0]} : s_w[W-1:0];
  assign r_sl  = byte_mode ? {{H{1'b0}}, a[H-2:0], 1'b0} : {a[W-2:0], 1'b0};
  assign r_lsr = byte_mode ? {{H{1'b0}}, 1'b0, a[H-1:1]} : {1'b0, a[W-1:1]};
  assign r_asr = byte_mode ? {{H{1'b0}}, a[H-1], a[H-1:1]} : {a[W-1], a[W-1:1]};

  logic c_ar, dc_ar, sa, sb, top, zero_now;
  assign c_ar  = byte_mode ? s_h[H] : s_w[W];
  assign dc_ar = byte_mode ? s_q[Q] : s_h[H];
  assign sa    = byte_mode ? a[H-1]  : a[W-1];
  assign sb    = byte_mode ? bx[H-1] : bx[W-1];
  assign top   = byte_mode ? result[H-1] : result[W-1];
  assign zero_now = ((result & mask) == '0);

  always_comb begin
    result = '0;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: result = r_sum;
      OP_AND: result = a & b & mask;
      OP_OR:  result = (a | b) & mask;
      OP_XOR: result = (a ^ b) & mask;
      OP_SL:  result = r_sl;
      OP_LSR: result = r_lsr;
      OP_ASR: result = r_asr;
      default: result = '0;
    endcase
  end

  always_comb begin
    flags_next = flags;
    if (is_arith) begin
      flags_next[FC] = c_ar;
      flags_next[FD] = dc_ar;
      flags_next[FV] = (sa == sb) && (top != sa);
      flags_next[FN] = top;
      flags_next[FZ] = is_ext ? (flags[FZ] & zero_now) : zero_now;
    end else if (is_logic) begin
      flags_next[FN] = top;
      flags_next[FZ] = zero_now;
    end else if (is_shift) begin
      flags_next[FC] = (op == OP_SL) ? (byte_mode ? a[H-1] : a[W-1]) : a[0];
      flags_next[FN] = top;
      flags_next[FZ] = zero_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  flags <= '0;
    else if (en) flags <= flags_next;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(flags));
  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> flags == $past(flags_next));
  p_byte_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> result[W-1:H] == '0);
  p_logic_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |-> (flags_next[FC] == flags[FC]) && (flags_next[FV] == flags[FV]) && (flags_next[FD] == flags[FD]));
  p_sticky_z_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en && is_ext && !flags[FZ] |=> !flags[FZ]);
  p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op > OP_ASR) |-> (flags_next == flags) && (result == '0));
endmodule

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, byte_mode = 1'b0, cin = 1'b0;
  logic [3:0] op = '0;
  logic [15:0] a = '0, b = '0;
  logic [15:0] result;
  logic [4:0] flags_next, flags;
  int errors = 0, checks = 0;
  logic [4:0] mflags = '0;

  typedef struct { logic [15:0] res; logic [4:0] nxt; logic [4:0] fq; string tag; } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  alu_flag_unit uut (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .byte_mode(byte_mode),
    .a(a), .b(b), .cin(cin), .result(result), .flags_next(flags_next), .flags(flags));

  function automatic logic [20:0] model(input logic [3:0] o, input logic bm, input logic [15:0] x,
                                        input logic [15:0] y, input logic c, input logic [4:0] fq);
    int w; logic [16:0] m, xm, ym, s; logic [16:0] dm; logic ci, n, z; logic [15:0] r; logic [4:0] f;
    w = bm ? 8 : 16;
    m = bm ? 17'h000FF : 17'h0FFFF;
    dm = bm ? 17'h0000F : 17'h000FF;
    xm = {1'b0, x} & m;
    f = fq; r = '0;
    if (o <= 4'd3) begin
      ym = (o >= 4'd2) ? ({1'b0, ~y} & m) : ({1'b0, y} & m);
      ci = (o == 4'd0) ? 1'b0 : (o == 4'd2) ? 1'b1 : c;
      s = xm + ym + {16'd0, ci};
      r = s[15:0] & m[15:0];
      n = r[w-1];
      z = (r == 16'd0);
      f[0] = s[w];
      f[4] = (((xm & dm) + (ym & dm) + {16'd0, ci}) >> (w / 2)) != 0;
      f[2] = (xm[w-1] == ym[w-1]) && (n != xm[w-1]);
      f[3] = n;
      f[1] = (o == 4'd1 || o == 4'd3) ? (fq[1] & z) : z;
    end else if (o <= 4'd9) begin
      case (o)
        4'd4: r = x & y;
        4'd5: r = x | y;
        4'd6: r = x ^ y;
        4'd7: begin r = x << 1; f[0] = x[w-1]; end
        4'd8: begin r = (x & m[15:0]) >> 1; f[0] = x[0]; end
        default: begin r = ((x & m[15:0]) >> 1) | (x[w-1] ? (16'd1 << (w-1)) : 16'd0); f[0] = x[0]; end
      endcase
      r = r & m[15:0];
      f[3] = r[w-1];
      f[1] = (r == 16'd0);
    end
    return {r, f};
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    if (o <= 4'd1) return "R1";
    if (o <= 4'd3) return "R2";
    if (o <= 4'd6) return "R8";
    if (o <= 4'd9) return "R9";
    return "R12";
  endfunction

  task automatic step(input logic [3:0] o, input logic bm, input logic [15:0] x, input logic [15:0] y,
                      input logic c, input logic e, input string tg);
    item_t it; logic [20:0] mv;
    @(negedge clk);
    op = o; byte_mode = bm; a = x; b = y; cin = c; en = e;
    mv = model(o, bm, x, y, c, mflags);
    it.res = mv[20:5]; it.nxt = mv[4:0]; it.fq = mflags;
    it.tag = (tg == "") ? tag_of(o) : tg;
    sb_q.push_back(it);
    if (e) mflags = mv[4:0];
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #5;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        checks++;
        if (result !== it.res || flags_next !== it.nxt || flags !== it.fq) begin
          errors++;
          $display("FAIL %s: result=%h flags_next=%b flags=%b expected result=%h flags_next=%b flags=%b",
                   it.tag, result, flags_next, flags, it.res, it.nxt, it.fq);
        end
      end
    end
  end

  bit finished = 0;
  initial begin : watchdog
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (2) @(negedge clk);
    checks++;
    if (flags !== 5'b0) begin
      errors++;
      $display("FAIL R11: reset flags=%b expected=%b", flags, 5'b0);
    end
    rst_n = 1'b1;
    step(4'd0, 0, 16'h7FFF, 16'h0001, 0, 1, "R5");
    step(4'd0, 0, 16'hFFFF, 16'h0001, 0, 1, "R1");
    step(4'd0, 1, 16'h120F, 16'h3401, 0, 1, "R3");
    step(4'd0, 0, 16'h00F0, 16'h0010, 0, 1, "R3");
    step(4'd2, 0, 16'h0005, 16'h0003, 0, 1, "R2");
    step(4'd2, 0, 16'h0003, 16'h0005, 0, 1, "R4");
    step(4'd2, 1, 16'hAA80, 16'h5501, 0, 1, "R5");
    step(4'd3, 0, 16'h0010, 16'h0001, 0, 1, "R2");
    step(4'd0, 0, 16'h0000, 16'h0000, 0, 1, "R6");
    step(4'd1, 0, 16'h0000, 16'h0000, 0, 1, "R7");
    step(4'd1, 0, 16'h0001, 16'h0000, 0, 1, "R7");
    step(4'd1, 0, 16'h0000, 16'h0000, 0, 1, "R7");
    step(4'd2, 1, 16'h0042, 16'h0042, 0, 1, "R6");
    step(4'd3, 1, 16'h0042, 16'h0042, 1, 1, "R7");
    step(4'd3, 1, 16'h0043, 16'h0042, 1, 1, "R7");
    step(4'd3, 1, 16'h0042, 16'h0042, 1, 1, "R7");
    step(4'd0, 0, 16'hFFFF, 16'hFFFF, 0, 1, "R1");
    step(4'd4, 0, 16'hF0F0, 16'h0FF0, 0, 1, "R8");
    step(4'd6, 0, 16'h8000, 16'h0000, 0, 1, "R8");
    step(4'd5, 1, 16'hFF00, 16'h0000, 0, 1, "R10");
    step(4'd7, 0, 16'h8001, 16'h0000, 0, 1, "R9");
    step(4'd7, 1, 16'h0080, 16'h0000, 0, 1, "R9");
    step(4'd8, 0, 16'h0003, 16'h0000, 0, 1, "R9");
    step(4'd9, 1, 16'hFF81, 16'h0000, 0, 1, "R9");
    step(4'd9, 0, 16'h8002, 16'h0000, 0, 1, "R9");
    step(4'd11, 0, 16'h1234, 16'h5678, 1, 1, "R12");
    step(4'd15, 1, 16'hFFFF, 16'hFFFF, 1, 1, "R12");
    step(4'd0, 1, 16'hABFF, 16'hCD01, 0, 1, "R10");
    step(4'd0, 0, 16'hFFFF, 16'h0001, 0, 0, "R11");
    step(4'd2, 0, 16'h0000, 16'h0001, 0, 0, "R11");
    step(4'd5, 0, 16'h0000, 16'h0000, 0, 1, "R11");
    for (int i = 0; i < 400; i++) begin
      step(4'($urandom_range(0, 11)), 1'($urandom), 16'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom_range(0, 3) != 0), "");
    end
    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule